// File: doc/BRIEF.md
# Pre-emptive Pulse-Signalled Bus Arbiter

This block arbitrates one shared bus among `NREQ` requesters, each with an active-low request line and an active-low grant line. Requests held low for two or more clocks are served round-robin, one owner at a time. A requester that needs urgent service signals it in-band on its request line: it drops the line for a single clock, lifts it for a single clock, and then drops it again and keeps it low.

On seeing that pulse pattern the arbiter takes the bus from any ordinary owner at once. It then waits until the bus-idle input shows the previous owner has gone, and grants the urgent requester. That grant lasts until the requester lifts its line. Urgent requests that arrive together, or while another urgent owner holds the bus, are queued and served lowest index first, ahead of any ordinary request. The bus-idle input comes from logic outside this block. The pins carry no data, so there is no valid/ready handshake.

Top module: `preempt_arbiter`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, every `gnt_n` bit is high.
- R2: At most one `gnt_n` bit is low in any cycle.
- R3: An ordinary request is a `req_n[i]` sampled low at two consecutive rising edges. A grant is issued only at an edge where no line is granted and `bus_idle` is high. `gnt_n[i]` goes low in the cycle after that edge.
- R4: Ordinary grants rotate. The search starts at the index after the last ordinary grantee and wraps from `NREQ-1` to 0. After reset the search starts at index 0.
- R5: A line sampled high, low, high, low at four consecutive edges raises an urgent request at the fourth edge. The lone low sample at the second edge does not lead to a grant.
- R6: A line that was low at two or more edges before going high for one edge and low again raises no urgent request. It is treated as an ordinary request.
- R7: When an urgent request is raised while an ordinary owner holds the bus, that owner's `gnt_n` is high in the cycle after the detecting edge.
- R8: A pending urgent request is granted at the first edge where no line is granted and `bus_idle` is high. It wins over every ordinary request.
- R9: An urgent grant is not withdrawn when another line raises an urgent request. The new request waits in the queue.
- R10: Urgent requests raised at the same edge are granted lowest index first. The others stay pending while their lines remain low, and are granted once the bus is free again.
- R11: A granted line whose `req_n` is sampled high at an edge has its `gnt_n` high in the cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| req_n | input | NREQ | Active-low request, one per requester |
| bus_idle | input | 1 | High when the previous owner has left the bus |
| gnt_n | output | NREQ | Active-low grant; bit i low grants requester i |

## Verification
Two events can fall on the same edge: an urgent pattern completing on one line, and an ordinary grant being held on another or starting there. The bench completes a pulse pattern on line 3 while line 0 is the ordinary owner and line 1 is also requesting. It judges that the grant is withdrawn on the very next cycle, and that line 3 rather than line 1 then gets the bus once `bus_idle` rises. A second case completes patterns on two lines at the same edge while a third line becomes an ordinary requester. The bench checks that the lower index is served first, that the queued line follows directly, and that the round-robin line comes after both.

// File: rtl/pa_pkg.sv
package pa_pkg;
  // Class of the current bus owner
  typedef enum logic {
    CLS_PLAIN  = 1'b0,
    CLS_URGENT = 1'b1
  } owner_cls_t;

  // Number of past request samples each line detector keeps
  localparam int HIST_DEPTH = 3;
endpackage

// File: rtl/pa_pulse_det.sv
module pa_pulse_det (
  input  logic clk,
  input  logic rst,
  input  logic req_act,
  output logic urgent_hit,
  output logic steady
);
  import pa_pkg::*;

  // hist[0] is the sample from the previous edge, hist[2] the oldest
  logic [HIST_DEPTH-1:0] hist;

  always_ff @(posedge clk) begin
    if (rst) hist <= '0;
    else     hist <= {hist[HIST_DEPTH-2:0], req_act};
  end

  // idle, active one edge, idle one edge, active again
  assign urgent_hit = req_act & ~hist[0] & hist[1] & ~hist[2];
  // active at this edge and the one before
  assign steady     = req_act & hist[0];
endmodule

// File: rtl/pa_rr_pick.sv
module pa_rr_pick #(
  parameter int NREQ = 4,
  parameter int IW   = 2
) (
  input  logic [NREQ-1:0] cand,
  input  logic [IW-1:0]   last,
  output logic            found,
  output logic [IW-1:0]   pick
);
  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int k = 1; k <= NREQ; k++) begin
      int c;
      c = int'(last) + k;
      if (c >= NREQ) c = c - NREQ;
      if (!found && cand[c]) begin
        found = 1'b1;
        pick  = IW'(c);
      end
    end
  end
endmodule

// File: rtl/pa_urgent_queue.sv
module pa_urgent_queue #(
  parameter int NREQ = 4,
  parameter int IW   = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NREQ-1:0] hit,
  input  logic [NREQ-1:0] req_act,
  input  logic            take,
  output logic            any,
  output logic [IW-1:0]   head
);
  logic [NREQ-1:0] pend;
  logic [NREQ-1:0] elig;
  logic [NREQ-1:0] taken;

  // a pending bit counts only while its line is still requesting
  assign elig = pend & req_act;
  assign any  = |elig;

  always_comb begin
    head = '0;
    for (int i = NREQ - 1; i >= 0; i--) begin
      if (elig[i]) head = IW'(i);
    end
  end

  always_comb begin
    taken = '0;
    if (take) taken[head] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else     pend <= (pend | hit) & req_act & ~taken;
  end
endmodule

// File: rtl/preempt_arbiter.sv
module preempt_arbiter #(
  parameter int NREQ = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NREQ-1:0] req_n,
  input  logic            bus_idle,
  output logic [NREQ-1:0] gnt_n
);
  import pa_pkg::*;

  localparam int IW = (NREQ > 1) ? $clog2(NREQ) : 1;

  logic [NREQ-1:0] req_act;
  logic [NREQ-1:0] hit;
  logic [NREQ-1:0] steady;
  logic            urg_any;
  logic [IW-1:0]   urg_head;
  logic            rr_found;
  logic [IW-1:0]   rr_pick;

  logic            own_v;
  logic [IW-1:0]   owner;
  owner_cls_t      own_cls;
  logic [IW-1:0]   rr_last;

  logic            release_bus;
  logic            preempt;
  logic            start_urgent;
  logic            start_plain;

  assign req_act = ~req_n;

  for (genvar g = 0; g < NREQ; g++) begin : g_line
    pa_pulse_det u_det (
      .clk       (clk),
      .rst       (rst),
      .req_act   (req_act[g]),
      .urgent_hit(hit[g]),
      .steady    (steady[g])
    );
  end

  pa_urgent_queue #(.NREQ(NREQ), .IW(IW)) u_queue (
    .clk    (clk),
    .rst    (rst),
    .hit    (hit),
    .req_act(req_act),
    .take   (start_urgent),
    .any    (urg_any),
    .head   (urg_head)
  );

  pa_rr_pick #(.NREQ(NREQ), .IW(IW)) u_rr (
    .cand (steady),
    .last (rr_last),
    .found(rr_found),
    .pick (rr_pick)
  );

  always_comb begin
    release_bus  = own_v & ~req_act[owner];
    preempt      = own_v & (own_cls == CLS_PLAIN) & (urg_any | (|hit));
    start_urgent = ~own_v & bus_idle & urg_any;
    start_plain  = ~own_v & bus_idle & ~urg_any & ~(|hit) & rr_found;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      own_v   <= 1'b0;
      owner   <= '0;
      own_cls <= CLS_PLAIN;
      rr_last <= IW'(NREQ - 1);
    end else if (own_v) begin
      if (release_bus || preempt) own_v <= 1'b0;
    end else if (start_urgent) begin
      own_v   <= 1'b1;
      owner   <= urg_head;
      own_cls <= CLS_URGENT;
    end else if (start_plain) begin
      own_v   <= 1'b1;
      owner   <= rr_pick;
      own_cls <= CLS_PLAIN;
      rr_last <= rr_pick;
    end
  end

  always_comb begin
    gnt_n = '1;
    if (own_v) gnt_n[owner] = 1'b0;
  end
endmodule

// File: rtl/pa_checker.sv
module pa_checker #(
  parameter int NREQ = 4
) (
  input logic            clk,
  input logic            rst,
  input logic [NREQ-1:0] req_n,
  input logic            bus_idle,
  input logic [NREQ-1:0] gnt_n
);
  AST_RESET_GNT_IDLE: assert property (@(posedge clk) rst |=> (&gnt_n)); // R1

  AST_SINGLE_GRANT: assert property (@(posedge clk) disable iff (rst)
    $countones(~gnt_n) <= 1); // R2

  for (genvar i = 0; i < NREQ; i++) begin : g_chk
    AST_GRANT_AFTER_IDLE: assert property (@(posedge clk) disable iff (rst)
      $fell(gnt_n[i]) |-> $past(bus_idle)); // R3

    AST_GRANT_FROM_FREE_BUS: assert property (@(posedge clk) disable iff (rst)
      $fell(gnt_n[i]) |-> $past(&gnt_n)); // R3

    AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
      !gnt_n[i] |-> $past(!req_n[i])); // R3

    AST_RELEASE_ON_REQ_HIGH: assert property (@(posedge clk) disable iff (rst)
      (!gnt_n[i] && req_n[i]) |=> gnt_n[i]); // R11
  end
endmodule

bind preempt_arbiter pa_checker #(.NREQ(NREQ)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .req_n   (req_n),
  .bus_idle(bus_idle),
  .gnt_n   (gnt_n)
);

// File: tb/preempt_arbiter_tb.sv
`timescale 1ns/1ps
module preempt_arbiter_tb;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] req_n = '1;
  logic         bus_idle = 1'b0;
  logic [N-1:0] gnt_n;

  int n_chk  = 0;
  int n_fail = 0;

  logic [N-1:0] exp_q[$];
  string        tag_q[$];
  logic [N-1:0] exp_v;
  string        tag_v;

  preempt_arbiter #(.NREQ(N)) u_dut (
    .clk(clk), .rst(rst), .req_n(req_n), .bus_idle(bus_idle), .gnt_n(gnt_n)
  );

  always #10 clk = ~clk;

  task automatic check(input logic ok, input string tag,
                       input logic [N-1:0] act, input logic [N-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: gnt_n=%b expected %b", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // driver: apply inputs for one edge, queue the grant expected after it
  task automatic step(input logic [N-1:0] rq, input logic idle,
                      input logic [N-1:0] exp, input string tag);
    @(negedge clk);
    req_n    = rq;
    bus_idle = idle;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  // monitor: compare after every edge that has a queued expectation
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      exp_v = exp_q.pop_front();
      tag_v = tag_q.pop_front();
      check(gnt_n === exp_v, tag_v, gnt_n, exp_v);
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 check(gnt_n === 4'hF, "R1 during reset", gnt_n, 4'hF);
    @(negedge clk) rst = 1'b0;
    @(posedge clk);
    #2 check(gnt_n === 4'hF, "R1 after reset", gnt_n, 4'hF);

    // ordinary request on line 0
    step(4'b1110, 1, 4'b1111, "R3 single low sample");
    step(4'b1110, 1, 4'b1110, "R3 grant line 0");
    step(4'b1110, 0, 4'b1110, "R11 hold while low");
    step(4'b1111, 0, 4'b1111, "R11 release");
    // line 0 low-low-high-low is not urgent; rotation from last=0
    step(4'b1000, 1, 4'b1111, "R6 no grant yet");
    step(4'b1000, 1, 4'b1101, "R6 R4 line 1 by rotation");
    step(4'b1010, 1, 4'b1111, "R11 line 1 release");
    step(4'b1010, 1, 4'b1011, "R4 line 2 next");
    step(4'b1110, 1, 4'b1111, "R11 line 2 release");
    step(4'b1110, 1, 4'b1110, "R4 wrap to line 0");
    step(4'b1111, 1, 4'b1111, "R11 line 0 release");

    // pulse pattern on line 2, bus free
    step(4'b1011, 1, 4'b1111, "R5 lone low not granted");
    step(4'b1111, 1, 4'b1111, "R5 high gap");
    step(4'b1011, 1, 4'b1111, "R5 pattern detected");
    step(4'b1011, 0, 4'b1111, "R8 waits for idle");
    step(4'b1011, 1, 4'b1011, "R8 urgent grant line 2");
    step(4'b1011, 0, 4'b1011, "R9 urgent hold");
    step(4'b1111, 0, 4'b1111, "R11 urgent release");

    // pre-emption of ordinary owner 0 by line 3, line 1 also waiting
    step(4'b1110, 1, 4'b1111, "R3 line 0 first sample");
    step(4'b1110, 1, 4'b1110, "R3 line 0 granted");
    step(4'b0100, 0, 4'b1110, "R2 owner kept");
    step(4'b1100, 0, 4'b1110, "R2 owner kept");
    step(4'b0100, 0, 4'b1111, "R7 withdrawn on pattern");
    step(4'b0100, 0, 4'b1111, "R8 no grant while busy");
    step(4'b0100, 1, 4'b0111, "R8 urgent line 3 beats line 1");
    // line 2 signals while line 3 holds urgently
    step(4'b0000, 1, 4'b0111, "R9 hold");
    step(4'b0100, 1, 4'b0111, "R9 hold");
    step(4'b0000, 1, 4'b0111, "R9 not preempted");
    step(4'b1000, 1, 4'b1111, "R11 line 3 release");
    step(4'b1000, 1, 4'b1011, "R8 queued line 2 before ordinary");
    step(4'b1100, 1, 4'b1111, "R11 line 2 release");
    step(4'b1100, 1, 4'b1101, "R4 line 1 after last 0");
    step(4'b1111, 1, 4'b1111, "R11 release");
    step(4'b1111, 1, 4'b1111, "R2 all idle");

    // simultaneous patterns on lines 1 and 3, line 2 ordinary
    step(4'b0101, 1, 4'b1111, "R10 first low");
    step(4'b1111, 1, 4'b1111, "R10 gap");
    step(4'b0101, 1, 4'b1111, "R10 both detected");
    step(4'b0101, 1, 4'b1101, "R10 lowest index first");
    step(4'b0001, 1, 4'b1101, "R10 hold line 1");
    step(4'b0011, 1, 4'b1111, "R11 line 1 release");
    step(4'b0011, 1, 4'b0111, "R10 queued line 3 before line 2");
    step(4'b1011, 1, 4'b1111, "R11 line 3 release");
    step(4'b1011, 1, 4'b1011, "R4 line 2 ordinary");
    step(4'b1111, 1, 4'b1111, "R11 line 2 release");

    wait (exp_q.size() == 0);
    repeat (2) @(posedge clk);
    #3 summary();
  end
endmodule